// File: doc/BRIEF.md
# Carrier Acquisition Sweep and Estimation Mode Controller

This block steers carrier recovery during signal acquisition. It drives the frequency word of a numerically controlled oscillator. At first it walks that word through a computed table of preset offsets. It stays at each offset for a programmable dwell. While the header peak detector reports that it is tracking a candidate peak, the block holds the current offset, and it tells the detector to start over each time the offset moves.

Once frame sync is declared, the controller keeps the offset it locked on and moves into a coarse estimation phase. Each per-frame coarse estimate is scaled down by a programmable right shift and added into the frequency word. After five consecutive coarse estimates that fall inside a programmable magnitude window, it moves on to fine estimation, which uses the fine estimates in the same way. Losing frame sync at any point sends it back to the first sweep offset.

Top module: `carrier_acq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, freqWord is 0 (table entry 0), mode is 0 (sweep) and detRestart is 0. Mode encoding: 0 sweep, 1 coarse, 2 fine.
- R2: The table entry k of an 8-entry table holds 0 for k=0, +((k+1)/2)*1000 for odd k and -(k/2)*1000 for even k. In sweep, with peakTrack and frameSync low, each entry is output for exactly max(cfgDwell,1) cycles, and then the next entry is output.
- R3: The entry after entry 7 is entry 0. The sweep wraps and does not stop.
- R4: detRestart is high for one cycle in the same cycle that freqWord takes a new table entry, and it is low in every other cycle.
- R5: In sweep, peakTrack high holds the current entry and restarts its dwell, so the entry advances only after max(cfgDwell,1) consecutive cycles without peakTrack.
- R6: frameSync high in sweep gives mode 1 on the next cycle and leaves freqWord at the locked entry.
- R7: In coarse mode, each coarseValid adds coarseEst arithmetically shifted right by cfgShift (rounding toward minus infinity) to freqWord, one cycle later. Coarse estimates have no effect in the other modes, and fine estimates have no effect in coarse mode.
- R8: In coarse mode, mode becomes 2 after the fifth consecutive coarseValid with |coarseEst| <= cfgFineRange. An out-of-range estimate restarts the count. Cycles without coarseValid do not break the count.
- R9: In fine mode, each fineValid adds fineEst shifted right by cfgShift to freqWord.
- R10: freqWord saturates at +32767 and -32768 and never wraps.
- R11: frameSync low in coarse or fine mode returns the controller on the next cycle to mode 0 at entry 0, with a detRestart pulse, and clears the in-range count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| peakTrack | input | 1 | Detector is tracking a peak above threshold |
| frameSync | input | 1 | Frame synchronization achieved |
| coarseValid | input | 1 | Strobe for coarseEst |
| coarseEst | input | 12 | Signed per-frame coarse offset estimate |
| fineValid | input | 1 | Strobe for fineEst |
| fineEst | input | 12 | Signed per-frame fine offset estimate |
| cfgDwell | input | 16 | Dwell length per sweep entry in cycles |
| cfgFineRange | input | 12 | Magnitude limit for an in-range coarse estimate |
| cfgShift | input | 4 | Loop gain as a right shift |
| freqWord | output | 16 | Signed oscillator frequency word |
| mode | output | 2 | Current phase: 0 sweep, 1 coarse, 2 fine |
| detRestart | output | 1 | One-cycle restart pulse to the peak detector |

## Verification
The bench walks the whole sweep table past its wrap point and checks every cycle. A dwell that is off by one cycle, or a wrap to the wrong entry, therefore shows up at once. It interrupts a dwell with peakTrack and also pulses estimates during the sweep, so a counter that does not restart, or an estimate that leaks into the word, changes freqWord. It breaks a run of in-range coarse estimates with one value just outside the window, and it re-enters coarse mode after a loss of sync. This catches a count that is not cleared, or that switches to fine mode too early. Long runs of extreme estimates push the word into both rails, where a wrapping adder would flip the sign.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    MODE_SWEEP  = 2'd0,
    MODE_COARSE = 2'd1,
    MODE_FINE   = 2'd2
  } acqMode_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic pointNext;   // step to next table entry (wrapping)
    logic pointFirst;  // jump back to entry 0
    logic addCoarse;   // accumulate scaled coarse estimate
    logic addFine;     // accumulate scaled fine estimate
  } acqStrobe_t;
endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int EST_W       = 12,
  parameter int DWELL_W     = 16,
  parameter int LOCK_FRAMES = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    peakTrack,
  input  logic                    frameSync,
  input  logic                    coarseValid,
  input  logic signed [EST_W-1:0] coarseEst,
  input  logic                    fineValid,
  input  logic [DWELL_W-1:0]      cfgDwell,
  input  logic [EST_W-1:0]        cfgFineRange,
  output acqMode_t                mode,
  output acqStrobe_t              strobe,
  output logic                    detRestart
);
  localparam int CNT_W = $clog2(LOCK_FRAMES + 1);

  logic [DWELL_W-1:0] dwellCnt, nextDwell;
  logic [DWELL_W:0]   dwellInc;
  logic [CNT_W-1:0]   inCnt, nextIn;
  acqMode_t           nextMode;
  logic               nextRestart;
  logic signed [EST_W:0] estWide;
  logic [EST_W:0]     estMag;
  logic               inRange;

  assign dwellInc = {1'b0, dwellCnt} + {{DWELL_W{1'b0}}, 1'b1};
  assign estWide  = {coarseEst[EST_W-1], coarseEst};
  assign estMag   = estWide[EST_W] ? $unsigned(-estWide) : $unsigned(estWide);
  assign inRange  = estMag <= {1'b0, cfgFineRange};

  always_comb begin
    strobe      = '0;
    nextMode    = mode;
    nextDwell   = dwellCnt;
    nextIn      = inCnt;
    nextRestart = 1'b0;
    case (mode)
      MODE_SWEEP: begin
        if (frameSync) begin
          nextMode  = MODE_COARSE;
          nextDwell = '0;
          nextIn    = '0;
        end else if (peakTrack) begin
          nextDwell = '0;
        end else if (dwellInc >= {1'b0, cfgDwell}) begin
          strobe.pointNext = 1'b1;
          nextDwell        = '0;
          nextRestart      = 1'b1;
        end else begin
          nextDwell = dwellInc[DWELL_W-1:0];
        end
      end
      MODE_COARSE: begin
        if (!frameSync) begin
          nextMode          = MODE_SWEEP;
          strobe.pointFirst = 1'b1;
          nextRestart       = 1'b1;
          nextIn            = '0;
          nextDwell         = '0;
        end else if (coarseValid) begin
          strobe.addCoarse = 1'b1;
          if (!inRange) begin
            nextIn = '0;
          end else if (inCnt == CNT_W'(LOCK_FRAMES - 1)) begin
            nextMode = MODE_FINE;
            nextIn   = '0;
          end else begin
            nextIn = inCnt + CNT_W'(1);
          end
        end
      end
      MODE_FINE: begin
        if (!frameSync) begin
          nextMode          = MODE_SWEEP;
          strobe.pointFirst = 1'b1;
          nextRestart       = 1'b1;
          nextIn            = '0;
          nextDwell         = '0;
        end else if (fineValid) begin
          strobe.addFine = 1'b1;
        end
      end
      default: nextMode = MODE_SWEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode       <= MODE_SWEEP;
      dwellCnt   <= '0;
      inCnt      <= '0;
      detRestart <= 1'b0;
    end else begin
      mode       <= nextMode;
      dwellCnt   <= nextDwell;
      inCnt      <= nextIn;
      detRestart <= nextRestart;
    end
  end

  // R8: in-range run counter never reaches the switch count
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    inCnt < CNT_W'(LOCK_FRAMES));
  // R8: entry to fine mode only on a coarse estimate
  a_r8_fine_entry: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_FINE && $past(mode) == MODE_COARSE) |-> $past(coarseValid));
  // R4: restart pulses only occur in sweep mode
  a_r4_restart_sweep: assert property (@(posedge clk) disable iff (!rstN)
    detRestart |-> mode == MODE_SWEEP);
  // R6: tracking modes need frame sync in the previous cycle
  a_r6_needs_sync: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_SWEEP) |-> $past(frameSync));
  // R5: tracking peak holds the entry
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SWEEP && peakTrack && !frameSync) |=> !detRestart);
endmodule

// File: rtl/acq_datapath.sv
module acq_datapath
  import acq_pkg::*;
#(
  parameter int FREQ_W  = 16,
  parameter int EST_W   = 12,
  parameter int SHIFT_W = 4,
  parameter int NUM_PTS = 8,
  parameter int STEP    = 1000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  acqStrobe_t               strobe,
  input  logic signed [EST_W-1:0]  coarseEst,
  input  logic signed [EST_W-1:0]  fineEst,
  input  logic [SHIFT_W-1:0]       cfgShift,
  output logic signed [FREQ_W-1:0] freqWord
);
  localparam int IDX_W = (NUM_PTS > 1) ? $clog2(NUM_PTS) : 1;
  localparam logic signed [FREQ_W-1:0] SAT_MAX = {1'b0, {(FREQ_W-1){1'b1}}};
  localparam logic signed [FREQ_W-1:0] SAT_MIN = {1'b1, {(FREQ_W-1){1'b0}}};

  // Entry k: 0, +S, -S, +2S, -2S, ...
  function automatic logic signed [FREQ_W-1:0] pointVal(input int k);
    int mag;
    mag = ((k + 1) / 2) * STEP;
    return (k % 2 == 1) ? FREQ_W'(mag) : FREQ_W'(-mag);
  endfunction

  logic signed [FREQ_W-1:0] romTab [NUM_PTS];
  for (genvar g = 0; g < NUM_PTS; g++) begin : g_rom
    assign romTab[g] = pointVal(g);
  end

  logic [IDX_W-1:0]         idx, idxNext;
  logic signed [EST_W-1:0]  estSel, shifted;
  logic signed [FREQ_W:0]   sumWide;
  logic signed [FREQ_W-1:0] satSum;
  logic                     doAdd;

  assign doAdd   = strobe.addCoarse | strobe.addFine;
  assign estSel  = strobe.addFine ? fineEst : coarseEst;
  assign shifted = estSel >>> cfgShift;
  assign sumWide = {freqWord[FREQ_W-1], freqWord}
                 + {{(FREQ_W + 1 - EST_W){shifted[EST_W-1]}}, shifted};
  assign idxNext = (idx == IDX_W'(NUM_PTS - 1)) ? '0 : idx + IDX_W'(1);

  always_comb begin
    if (sumWide[FREQ_W] != sumWide[FREQ_W-1])
      satSum = sumWide[FREQ_W] ? SAT_MIN : SAT_MAX;
    else
      satSum = sumWide[FREQ_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx      <= '0;
      freqWord <= romTab[0];
    end else if (strobe.pointFirst) begin
      idx      <= '0;
      freqWord <= romTab[0];
    end else if (strobe.pointNext) begin
      idx      <= idxNext;
      freqWord <= romTab[idxNext];
    end else if (doAdd) begin
      freqWord <= satSum;
    end
  end

  // R10: adding a non-negative step to a non-negative word stays non-negative
  a_r10_no_wrap_up: assert property (@(posedge clk) disable iff (!rstN)
    (doAdd && !strobe.pointFirst && !freqWord[FREQ_W-1] && !shifted[EST_W-1])
      |=> !freqWord[FREQ_W-1]);
  // R10: adding a negative step to a negative word stays negative
  a_r10_no_wrap_down: assert property (@(posedge clk) disable iff (!rstN)
    (doAdd && !strobe.pointFirst && freqWord[FREQ_W-1] && shifted[EST_W-1])
      |=> freqWord[FREQ_W-1]);
  // R2: word holds when no strobe is raised
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(doAdd || strobe.pointNext || strobe.pointFirst) |=> $stable(freqWord));
endmodule

// File: rtl/carrier_acq_ctrl.sv
module carrier_acq_ctrl
  import acq_pkg::*;
#(
  parameter int FREQ_W      = 16,
  parameter int EST_W       = 12,
  parameter int DWELL_W     = 16,
  parameter int SHIFT_W     = 4,
  parameter int NUM_PTS     = 8,
  parameter int STEP        = 1000,
  parameter int LOCK_FRAMES = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     peakTrack,
  input  logic                     frameSync,
  input  logic                     coarseValid,
  input  logic signed [EST_W-1:0]  coarseEst,
  input  logic                     fineValid,
  input  logic signed [EST_W-1:0]  fineEst,
  input  logic [DWELL_W-1:0]       cfgDwell,
  input  logic [EST_W-1:0]         cfgFineRange,
  input  logic [SHIFT_W-1:0]       cfgShift,
  output logic signed [FREQ_W-1:0] freqWord,
  output logic [1:0]               mode,
  output logic                     detRestart
);
  acqMode_t   modeInt;
  acqStrobe_t strobe;

  acq_ctrl #(.EST_W(EST_W), .DWELL_W(DWELL_W), .LOCK_FRAMES(LOCK_FRAMES)) u_ctrl (
    .clk(clk), .rstN(rstN), .peakTrack(peakTrack), .frameSync(frameSync),
    .coarseValid(coarseValid), .coarseEst(coarseEst), .fineValid(fineValid),
    .cfgDwell(cfgDwell), .cfgFineRange(cfgFineRange),
    .mode(modeInt), .strobe(strobe), .detRestart(detRestart)
  );

  acq_datapath #(.FREQ_W(FREQ_W), .EST_W(EST_W), .SHIFT_W(SHIFT_W),
                 .NUM_PTS(NUM_PTS), .STEP(STEP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .coarseEst(coarseEst),
    .fineEst(fineEst), .cfgShift(cfgShift), .freqWord(freqWord)
  );

  assign mode = modeInt;
endmodule

// File: tb/carrier_acq_ctrl_tb.sv
module carrier_acq_ctrl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic peakTrack = 1'b0, frameSync = 1'b0, coarseValid = 1'b0, fineValid = 1'b0;
  logic signed [11:0] coarseEst = '0, fineEst = '0;
  logic [15:0] cfgDwell = 16'd3;
  logic [11:0] cfgFineRange = 12'd40;
  logic [3:0]  cfgShift = 4'd2;
  logic signed [15:0] freqWord;
  logic [1:0] mode;
  logic detRestart;

  int nChecks = 0, nFail = 0;
  int expF;

  always #10 clk = ~clk;

  carrier_acq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .peakTrack(peakTrack), .frameSync(frameSync),
    .coarseValid(coarseValid), .coarseEst(coarseEst), .fineValid(fineValid),
    .fineEst(fineEst), .cfgDwell(cfgDwell), .cfgFineRange(cfgFineRange),
    .cfgShift(cfgShift), .freqWord(freqWord), .mode(mode), .detRestart(detRestart)
  );

  function automatic int pt(input int k);
    if (k == 0) return 0;
    return (k % 2 == 1) ? ((k + 1) / 2) * 1000 : -(k / 2) * 1000;
  endfunction

  function automatic int sat(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic state(input string req, input int f, input int m, input int r);
    chk({req, " freqWord"}, int'(freqWord), f);
    chk({req, " mode"}, int'(mode), m);
    chk({req, " detRestart"}, int'(detRestart), r);
  endtask

  task automatic doReset();
    rstN = 1'b0; peakTrack = 0; frameSync = 0; coarseValid = 0; fineValid = 0;
    step(); step();
    rstN = 1'b1;
  endtask

  task automatic coarse(input int e, input int m);
    coarseEst = 12'(e); coarseValid = 1'b1;
    step();
    coarseValid = 1'b0;
    expF = sat(expF + (e >>> int'(cfgShift)));
    state("R7/R8 coarse", expF, m, 0);
  endtask

  task automatic fine(input int e);
    fineEst = 12'(e); fineValid = 1'b1;
    step();
    fineValid = 1'b0;
    expF = sat(expF + (e >>> int'(cfgShift)));
    state("R9/R10 fine", expF, 2, 0);
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    // R1 reset state
    rstN = 1'b0;
    step(); step();
    state("R1 in reset", 0, 0, 0);
    rstN = 1'b1;
    #2;
    state("R1 after release", 0, 0, 0);

    // R2/R3/R4: sweep with dwell 3 past the wrap
    for (int p = 0; p <= 8; p++) begin
      for (int c = 1; c <= 3; c++) begin
        step();
        if (c < 3) state("R2 dwell", pt(p % 8), 0, 0);
        else       state("R3/R4 advance", pt((p + 1) % 8), 0, 1);
      end
    end

    // R2: dwell 1 advances every cycle
    cfgDwell = 16'd1;
    doReset();
    for (int k = 1; k <= 3; k++) begin
      step();
      state("R2 dwell1", pt(k), 0, 1);
    end

    // R5: peakTrack holds entry; R7: estimates ignored in sweep
    cfgDwell = 16'd3;
    doReset();
    step(); step();
    peakTrack = 1'b1;
    for (int k = 0; k < 5; k++) begin
      coarseEst = 12'sd400; coarseValid = (k == 2);
      fineEst = 12'sd400; fineValid = (k == 3);
      step();
      state("R5/R7 hold", 0, 0, 0);
    end
    coarseValid = 0; fineValid = 0; peakTrack = 1'b0;
    step(); state("R5 restart dwell", 0, 0, 0);
    step(); state("R5 restart dwell", 0, 0, 0);
    step(); state("R5 advance", 1000, 0, 1);

    // R6: frame sync locks entry 1
    frameSync = 1'b1;
    step(); state("R6 enter coarse", 1000, 1, 0);
    for (int k = 0; k < 4; k++) begin
      step(); state("R6 stays", 1000, 1, 0);
    end

    // R7/R8 coarse accumulate and in-range run
    expF = 1000;
    coarse(100, 1);
    coarse(-7, 1);
    fineEst = 12'sd400; fineValid = 1'b1;
    step(); fineValid = 1'b0;
    state("R7 fine ignored in coarse", expF, 1, 0);
    coarse(40, 1);
    coarse(40, 1);
    coarse(41, 1);          // out of range: count restarts
    coarse(40, 1);
    coarse(-40, 1);
    coarse(40, 1);
    coarse(-40, 1);
    step(); state("R8 gap", expF, 1, 0);
    coarse(-40, 2);         // fifth in a row

    // R9 fine mode
    coarseEst = 12'sd400; coarseValid = 1'b1;
    step(); coarseValid = 1'b0;
    state("R9 coarse ignored in fine", expF, 2, 0);
    fine(64);
    fine(-100);

    // R10 saturation both ways
    cfgShift = 4'd0;
    for (int k = 0; k < 20; k++) fine(2047);
    chk("R10 top rail", int'(freqWord), 32767);
    for (int k = 0; k < 40; k++) fine(-2048);
    chk("R10 bottom rail", int'(freqWord), -32768);

    // R11 loss of sync
    frameSync = 1'b0;
    step(); state("R11 back to sweep", 0, 0, 1);
    step(); state("R11 pulse ends", 0, 0, 0);
    frameSync = 1'b1;
    step(); state("R11 re-enter coarse", 0, 1, 0);
    expF = 0;
    for (int k = 0; k < 4; k++) coarse(10, 1);
    coarse(10, 2);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule